// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K locations, each 8 bits wide. The host raises a request together with a 19-bit address, a write flag and write data. The request is taken in the cycle where the controller shows ready. The controller then drives the RAM's chip-enable, write-enable and output-enable strobes in a fixed sequence. It also holds the address steady and drives a split data bus (value, drive enable, returned value) into an external tristate pad.

Each phase of an access lasts a whole number of clock cycles. That number is worked out when the design is built, from the clock period and the RAM's minimum timings in picoseconds. The rule is the ceiling of span over period, and never less than one cycle. A read returns its byte on a one-cycle valid pulse. Bus ownership changes hands with a gap, so the controller and the RAM never drive the data pins at the same time.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, ready is 1. The three strobes (chip enable, write enable, output enable; all active low) are 1. The data-bus drive enable is 0 and the read-valid pulse is 0.
- R2: A request is taken only on a clock edge where both req and ready are 1. Ready is 0 from the cycle after that edge until the access has finished. While ready is 1 all strobes stay high, and with req at 0 no strobe ever falls.
- R3: In a write, write enable is low only while chip enable is low and output enable is high. It stays low for PULSE cycles, where PULSE is the ceiling of max(write pulse, data setup) over the period. The write data is driven on the bus for the whole pulse.
- R4: Before write enable falls, and before output enable falls in a read, chip enable is low for SETUP cycles. SETUP is the ceiling of (address-valid-to-end-of-write minus write pulse) over the period. The address equals the requested address, unchanged, in every cycle that chip enable is low.
- R5: In a read, output enable is low with chip enable low and write enable high for ACC cycles, where ACC is the ceiling of the address access time over the period. The byte present on the bus at the edge that ends this phase appears on rdata. rvalid is 1 for exactly one cycle.
- R6: The data-bus drive enable is never 1 in a cycle where output enable is low.
- R7: When the drive enable turns on, the cycle before had output enable high and the drive enable off. A write that follows a read therefore always has at least one turnaround cycle.
- R8: After every access, chip enable goes high for REC cycles before ready returns. REC is the ceiling of the output high-Z time over the period. A write therefore takes SETUP+PULSE+REC busy cycles and a read takes SETUP+ACC+REC.
- R9: Every phase count is at least one cycle. With an 8 ns clock and the default timings, the counts are SETUP=1, PULSE=1, ACC=2, REC=1.
- R10: All 19 address bits reach the RAM. The lowest address, the highest address (0x7FFFF) and alternating-bit addresses each keep their own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request, taken when ready is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Host address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle and able to take a request |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | One-cycle pulse marking rdata valid |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Value to drive onto the RAM data pins |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Value read from the RAM data pins |

## Verification
Data patterns of all zeros, all ones and alternating bits are written to the lowest address, the highest address and alternating-bit addresses, then read back. A stuck or dropped address or data bit therefore gives a wrong byte. The model RAM returns a filler byte whenever it is not selected for reading, so a capture on the wrong edge or with the wrong strobes also gives a wrong byte.

Strobe phases are counted in every access and compared with counts the bench derives on its own from the picosecond timings. This separates an extra or missing cycle in each phase.

Reads followed by writes, writes followed by reads, and idle stretches with no request check three things: the bus turnaround, that drive and output enable never overlap, and that nothing moves without a request.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WPULSE,
    ST_RWAIT,
    ST_RECOVER
  } sram_state_e;

  // Cycles needed to cover span_ps at period clk_ps: ceiling, never below one.
  function automatic int phase_cycles(input int span_ps, input int clk_ps);
    int n;
    n = (span_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign done = (remain == '0);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_nxt,
  input  logic              capture,
  input  logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      if (accept)  mem_dq_out <= wdata;
      mem_dq_oe <= drive_nxt;
      if (capture) rdata <= mem_dq_in;
      rvalid <= capture;
    end
  end

  // R6: the pad never drives while the RAM has its outputs enabled
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7: drive turns on only after a cycle with output enable high
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R5: read valid is a single-cycle pulse
  assert_rvalid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 8000,
  parameter int T_AW_PS = 10000,
  parameter int T_WP_PS = 8000,
  parameter int T_DS_PS = 6000,
  parameter int T_AA_PS = 10000,
  parameter int T_HZ_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int SETUP_CYC = phase_cycles(max2(T_AW_PS - T_WP_PS, 0), CLK_PS);
  localparam int PULSE_CYC = phase_cycles(max2(T_WP_PS, T_DS_PS), CLK_PS);
  localparam int ACC_CYC   = phase_cycles(T_AA_PS, CLK_PS);
  localparam int REC_CYC   = phase_cycles(T_HZ_PS, CLK_PS);
  localparam int MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(ACC_CYC, REC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC) + 1;

  sram_state_e      state, nxt;
  logic             is_wr;
  logic             accept;
  logic             phase_done;
  logic             capture;
  logic             drive_nxt;
  logic             t_load;
  logic [CNT_W-1:0] t_val;

  assign ready   = (state == ST_IDLE);
  assign accept  = req && ready;
  assign capture = (state == ST_RWAIT) && phase_done;

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        nxt = ST_SETUP;   t_load = 1'b1; t_val = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (phase_done) begin
        t_load = 1'b1;
        if (is_wr) begin nxt = ST_WPULSE; t_val = CNT_W'(PULSE_CYC - 1); end
        else       begin nxt = ST_RWAIT;  t_val = CNT_W'(ACC_CYC - 1);   end
      end
      ST_WPULSE, ST_RWAIT: if (phase_done) begin
        nxt = ST_RECOVER; t_load = 1'b1; t_val = CNT_W'(REC_CYC - 1);
      end
      ST_RECOVER: if (phase_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // Keep driving for the recovery cycle after a pulse: zero data hold, no race at the rising edge.
  assign drive_nxt = (nxt == ST_WPULSE) || (state == ST_WPULSE && nxt == ST_RECOVER);

  // Strobes are registered from the next state so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_wr    <= 1'b0;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
    end else begin
      state    <= nxt;
      if (accept) begin
        is_wr    <= wr;
        mem_addr <= addr;
      end
      mem_ce_n <= !(nxt == ST_SETUP || nxt == ST_WPULSE || nxt == ST_RWAIT);
      mem_we_n <= (nxt != ST_WPULSE);
      mem_oe_n <= (nxt != ST_RWAIT);
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (phase_done)
  );

  sram_data_path #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .wdata      (wdata),
    .drive_nxt  (drive_nxt),
    .capture    (capture),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_in  (mem_dq_in),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

  // R2: while idle every strobe is inactive
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

  // R3: write pulse only with chip selected, outputs off and data driven
  assert_we_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R4: chip selected in the cycle before the write pulse, address held through it
  assert_setup_before_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  // R5: output enable only in a selected read
  assert_read_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R8: deselect is followed by recovery, not straight into ready
  assert_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> !ready);

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int PERIOD_PS = 8000;
  localparam int AW_PS = 10000, WP_PS = 8000, DS_PS = 6000, AA_PS = 10000, HZ_PS = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #4ns clk = ~clk;

  sram_ctrl #(.CLK_PS(PERIOD_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // Phase length restated as the smallest whole cycle count covering the span.
  function automatic int need_cycles(input int span_ps);
    int n;
    n = 1;
    while (n * PERIOD_PS < span_ps) n++;
    return n;
  endfunction

  int e_setup, e_pulse, e_acc, e_rec;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // RAM model and bus monitors, all sampled at the falling edge.
  logic [7:0] mem [logic [18:0]];
  int  n_contend = 0, n_turn_bad = 0, n_undriven_wr = 0;
  logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n) begin
        if (!mem_dq_oe) n_undriven_wr++;
        mem[mem_addr] = mem_dq_out;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
        mem_dq_in <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
      else
        mem_dq_in <= 8'hEE;
      if (mem_dq_oe && !mem_oe_n) n_contend++;
      if (mem_dq_oe && !prev_dq_oe && !prev_oe_n) n_turn_bad++;
      prev_oe_n  = mem_oe_n;
      prev_dq_oe = mem_dq_oe;
    end
  end

  int m_setup, m_pulse, m_oe, m_rec, m_rv, m_busy, m_addr_bad;
  logic [7:0] m_rd;

  task automatic run_op(input logic w, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    m_setup = 0; m_pulse = 0; m_oe = 0; m_rec = 0; m_rv = 0; m_busy = 0; m_addr_bad = 0; m_rd = 8'h00;
    for (int i = 0; i < 40 && !ready; i++) begin
      if (!mem_ce_n) begin
        if (mem_addr != a) m_addr_bad++;
        if (!mem_we_n)      m_pulse++;
        else if (!mem_oe_n) m_oe++;
        else if (m_pulse == 0 && m_oe == 0) m_setup++;
      end else m_rec++;
      if (rvalid) begin m_rv++; m_rd = rdata; end
      m_busy++;
      @(negedge clk);
    end
    if (rvalid) m_rv++;
  endtask

  task automatic t_reset;
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes after reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(mem_dq_oe == 1'b0 && rvalid == 1'b0, "R1 drive/rvalid after reset",
        {mem_dq_oe, rvalid}, 0);
  endtask

  task automatic t_idle_no_req;
    int moved;
    moved = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || !ready) moved++;
    end
    chk(moved == 0, "R2 no strobe without request", moved, 0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    run_op(1'b1, a, d);
    chk(m_setup == e_setup, "R4 write setup cycles", m_setup, e_setup);
    chk(m_pulse == e_pulse, "R3 write pulse cycles", m_pulse, e_pulse);
    chk(m_rec == e_rec, "R8 write recovery cycles", m_rec, e_rec);
    chk(m_busy == e_setup + e_pulse + e_rec, "R2 R9 write busy cycles", m_busy, e_setup + e_pulse + e_rec);
    chk(m_addr_bad == 0, "R4 R10 write address held", m_addr_bad, 0);
    chk(m_oe == 0 && m_rv == 0, "R3 no read strobe in write", m_oe + m_rv, 0);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp_d);
    run_op(1'b0, a, 8'h00);
    chk(m_setup == e_setup, "R4 read setup cycles", m_setup, e_setup);
    chk(m_oe == e_acc, "R5 read access cycles", m_oe, e_acc);
    chk(m_rv == 1, "R5 rvalid one cycle", m_rv, 1);
    chk(m_rd == exp_d, "R5 R10 read data", m_rd, exp_d);
    chk(m_rec == e_rec, "R8 read recovery cycles", m_rec, e_rec);
    chk(m_busy == e_setup + e_acc + e_rec, "R2 read busy cycles", m_busy, e_setup + e_acc + e_rec);
    chk(m_addr_bad == 0 && m_pulse == 0, "R10 read address held, no write", m_addr_bad + m_pulse, 0);
  endtask

  task automatic t_patterns;
    t_write(19'h00000, 8'h00);
    t_write(19'h7FFFF, 8'hFF);
    t_write(19'h2AAAA, 8'hA5);
    t_write(19'h55555, 8'h5A);
    t_read(19'h00000, 8'h00);
    t_read(19'h7FFFF, 8'hFF);
    t_read(19'h2AAAA, 8'hA5);
    t_read(19'h55555, 8'h5A);
  endtask

  task automatic t_turnaround;
    // write directly after read, then read directly after write
    t_read(19'h7FFFF, 8'hFF);
    t_write(19'h12345, 8'h3C);
    t_read(19'h12345, 8'h3C);
    t_write(19'h7FFFF, 8'h81);
    t_read(19'h7FFFF, 8'h81);
    chk(n_turn_bad == 0, "R7 turnaround before drive", n_turn_bad, 0);
    chk(n_contend == 0, "R6 no drive with output enable", n_contend, 0);
    chk(n_undriven_wr == 0, "R3 data driven in pulse", n_undriven_wr, 0);
  endtask

  task automatic t_counts;
    chk(e_setup == 1 && e_pulse == 1 && e_acc == 2 && e_rec == 1, "R9 default phase counts",
        {e_setup[3:0], e_pulse[3:0], e_acc[3:0], e_rec[3:0]}, 16'h1121);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    e_setup = need_cycles((AW_PS > WP_PS) ? AW_PS - WP_PS : 0);
    e_pulse = need_cycles((WP_PS > DS_PS) ? WP_PS : DS_PS);
    e_acc   = need_cycles(AA_PS);
    e_rec   = need_cycles(HZ_PS);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counts();
    t_idle_no_req();
    t_patterns();
    t_turnaround();
    t_idle_no_req();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule